// File: doc/BRIEF.md
# Core Morph Swap Rule Evaluator

This block decides, once per profiling window, what a tightly coupled pair of asymmetric cores should do next. One core is strong at integer work and the other at floating-point work. The pair can also be fused so that one thread gets a strong combined core while the other thread is demoted to a weak core. Two per-thread profilers each supply three values for the window: the integer share, the floating-point share and the IPC. The current configuration is also an input. When both profilers signal a finished window in the same cycle, the block evaluates fixed percentage windows and registers one decision: stay, exchange the two threads, fuse with a named thread on the strong core, or leave the fused mode with a chosen baseline placement.

The decision is only a proposal. Filtering over several windows, draining the pipeline and moving thread context are handled elsewhere. Percentages are unsigned integers from 0 to 100. IPC is an unsigned fixed-point code with `IPC_FRAC` fraction bits.

Top module: `morph_rule_eval`

## Requirements
- R1: In the cycle after a clock edge at which `win_vld_t0_i` and `win_vld_t1_i` are both high, `dec_vld_o` is high for one cycle with the decision on `dec_code_o` (0 stay, 1 exchange threads, 2 fuse with thread 0 strong, 3 fuse with thread 1 strong, 4 leave fused mode with thread 0 on the integer core, 5 leave fused mode with thread 1 on the integer core). After any other edge, `dec_vld_o` is low and `dec_code_o` is 0.
- R2: `cfg_i` is encoded as 0 = baseline with thread 0 on the integer core, 1 = baseline with thread 1 on the integer core, 2 = fused with thread 0 strong, 3 = fused with thread 1 strong. In baseline, an exchange is proposed when the thread on the floating-point core has integer share ≥ 44 and the thread on the integer core has integer share ≤ 30.
- R3: In baseline, an exchange is also proposed when the thread on the integer core has floating-point share ≥ 26 and the thread on the floating-point core has floating-point share ≤ 13.
- R4: A thread qualifies for the strong core when integer plus floating-point ≥ 50, floating-point is in 17..30 and integer is in 26..44, all bounds inclusive.
- R5: The other thread qualifies for the weak core only when its IPC code ≤ floor(0.4·2^IPC_FRAC) (102 for IPC_FRAC = 8) and its integer plus floating-point < 60. Fusing is proposed only when both threads qualify in the same window.
- R6: Both orderings are checked. If each thread could take the strong core, the thread currently on the integer core is chosen.
- R7: In baseline, a fusing proposal takes priority over an exchange proposal.
- R8: While fused, the block proposes leaving when the strong thread's integer plus floating-point < 50, and proposes stay otherwise. The exchange and fusing rules have no effect in this mode.
- R9: When leaving the fused mode, the placement is set by the R2 and R3 rules evaluated with thread 0 on the integer core: code 5 if either rule holds, code 4 if neither holds.
- R10: While `rst_n` is low, `dec_vld_o` is 0 and `dec_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_vld_t0_i | input | 1 | Thread 0 profiler window complete |
| win_vld_t1_i | input | 1 | Thread 1 profiler window complete |
| int_pct_t0_i | input | PCT_W | Thread 0 integer share, percent |
| fp_pct_t0_i | input | PCT_W | Thread 0 floating-point share, percent |
| ipc_t0_i | input | IPC_W | Thread 0 IPC, fixed point |
| int_pct_t1_i | input | PCT_W | Thread 1 integer share, percent |
| fp_pct_t1_i | input | PCT_W | Thread 1 floating-point share, percent |
| ipc_t1_i | input | IPC_W | Thread 1 IPC, fixed point |
| cfg_i | input | 2 | Current configuration and placement |
| dec_vld_o | output | 1 | Decision valid |
| dec_code_o | output | 3 | Decision code |

## Verification
The hardest case to reach from the ports is a window in which several rules hold at once. Examples are a thread mix that satisfies both the exchange rule and the fusing rule, a pair in which either thread could take the strong core, and a fused configuration whose inputs would trigger an exchange or a fusing proposal in baseline. The stimulus table builds these windows on purpose, with shares placed exactly on each inclusive or exclusive bound and one step past it. It then replays the same thread mix under a different `cfg_i`, so that a change in the result can only come from the placement and priority logic.

// File: rtl/morph_pkg.sv
package morph_pkg;

    typedef enum logic [1:0] {
        CFG_BASE_NORM = 2'd0,
        CFG_BASE_SWAP = 2'd1,
        CFG_FUSE_T0   = 2'd2,
        CFG_FUSE_T1   = 2'd3
    } cfg_e;

    typedef enum logic [2:0] {
        DEC_STAY      = 3'd0,
        DEC_SWAP      = 3'd1,
        DEC_FUSE_T0   = 3'd2,
        DEC_FUSE_T1   = 3'd3,
        DEC_EXIT_NORM = 3'd4,
        DEC_EXIT_SWAP = 3'd5
    } dec_e;

    // per-thread threshold flags
    typedef struct packed {
        logic strong_ok;
        logic weak_ok;
        logic int_hi;
        logic int_lo;
        logic fp_hi;
        logic fp_lo;
        logic mix_lo;
    } cls_t;

endpackage

// File: rtl/morph_thread_cls.sv
module morph_thread_cls
    import morph_pkg::*;
#(
    parameter int PCT_W        = 7,
    parameter int IPC_W        = 10,
    parameter int IPC_FRAC     = 8,
    parameter int IPC_NUM      = 4,
    parameter int IPC_DEN      = 10,
    parameter int SWP_INT_HI   = 44,
    parameter int SWP_INT_LO   = 30,
    parameter int SWP_FP_HI    = 26,
    parameter int SWP_FP_LO    = 13,
    parameter int MIX_MIN      = 50,
    parameter int STR_FP_MIN   = 17,
    parameter int STR_FP_MAX   = 30,
    parameter int STR_INT_MIN  = 26,
    parameter int STR_INT_MAX  = 44,
    parameter int WEAK_MIX_LIM = 60
) (
    input  logic [PCT_W-1:0] int_pct_i,
    input  logic [PCT_W-1:0] fp_pct_i,
    input  logic [IPC_W-1:0] ipc_i,
    output cls_t             cls_o
);
    localparam int SUM_W = PCT_W + 1;
    localparam logic [IPC_W-1:0] IPC_LIM = IPC_W'((IPC_NUM << IPC_FRAC) / IPC_DEN);

    logic [SUM_W-1:0] mix;
    logic             int_in_band;
    logic             fp_in_band;

    always_comb begin
        mix         = {1'b0, int_pct_i} + {1'b0, fp_pct_i};
        int_in_band = (int_pct_i >= PCT_W'(STR_INT_MIN)) && (int_pct_i <= PCT_W'(STR_INT_MAX));
        fp_in_band  = (fp_pct_i  >= PCT_W'(STR_FP_MIN))  && (fp_pct_i  <= PCT_W'(STR_FP_MAX));

        cls_o.mix_lo    = mix < SUM_W'(MIX_MIN);
        cls_o.strong_ok = !cls_o.mix_lo && int_in_band && fp_in_band;
        cls_o.weak_ok   = (ipc_i <= IPC_LIM) && (mix < SUM_W'(WEAK_MIX_LIM));
        cls_o.int_hi    = int_pct_i >= PCT_W'(SWP_INT_HI);
        cls_o.int_lo    = int_pct_i <= PCT_W'(SWP_INT_LO);
        cls_o.fp_hi     = fp_pct_i  >= PCT_W'(SWP_FP_HI);
        cls_o.fp_lo     = fp_pct_i  <= PCT_W'(SWP_FP_LO);
    end

endmodule

// File: rtl/morph_decide.sv
module morph_decide
    import morph_pkg::*;
(
    input  cfg_e cfg_i,
    input  cls_t cls_t0_i,
    input  cls_t cls_t1_i,
    output dec_e dec_o
);
    cls_t cls_on_int;
    cls_t cls_on_fp;
    cls_t cls_strong;
    logic swap_here;
    logic swap_norm;
    logic fuse0;
    logic fuse1;
    logic t1_on_int;

    always_comb begin
        t1_on_int  = (cfg_i == CFG_BASE_SWAP);
        cls_on_int = t1_on_int ? cls_t1_i : cls_t0_i;
        cls_on_fp  = t1_on_int ? cls_t0_i : cls_t1_i;

        // exchange rules for the present placement
        swap_here = (cls_on_fp.int_hi && cls_on_int.int_lo) ||
                    (cls_on_int.fp_hi && cls_on_fp.fp_lo);
        // exchange rules with thread 0 on the integer core
        swap_norm = (cls_t1_i.int_hi && cls_t0_i.int_lo) ||
                    (cls_t0_i.fp_hi && cls_t1_i.fp_lo);

        fuse0 = cls_t0_i.strong_ok && cls_t1_i.weak_ok;
        fuse1 = cls_t1_i.strong_ok && cls_t0_i.weak_ok;

        cls_strong = (cfg_i == CFG_FUSE_T1) ? cls_t1_i : cls_t0_i;

        dec_o = DEC_STAY;
        unique case (cfg_i)
            CFG_BASE_NORM, CFG_BASE_SWAP: begin
                if (fuse0 && fuse1)
                    dec_o = t1_on_int ? DEC_FUSE_T1 : DEC_FUSE_T0;
                else if (fuse0)
                    dec_o = DEC_FUSE_T0;
                else if (fuse1)
                    dec_o = DEC_FUSE_T1;
                else if (swap_here)
                    dec_o = DEC_SWAP;
            end
            default: begin
                if (cls_strong.mix_lo)
                    dec_o = swap_norm ? DEC_EXIT_SWAP : DEC_EXIT_NORM;
            end
        endcase
    end

endmodule

// File: rtl/morph_rule_eval.sv
module morph_rule_eval
    import morph_pkg::*;
#(
    parameter int PCT_W        = 7,
    parameter int IPC_W        = 10,
    parameter int IPC_FRAC     = 8,
    parameter int IPC_NUM      = 4,
    parameter int IPC_DEN      = 10,
    parameter int SWP_INT_HI   = 44,
    parameter int SWP_INT_LO   = 30,
    parameter int SWP_FP_HI    = 26,
    parameter int SWP_FP_LO    = 13,
    parameter int MIX_MIN      = 50,
    parameter int STR_FP_MIN   = 17,
    parameter int STR_FP_MAX   = 30,
    parameter int STR_INT_MIN  = 26,
    parameter int STR_INT_MAX  = 44,
    parameter int WEAK_MIX_LIM = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_vld_t0_i,
    input  logic             win_vld_t1_i,
    input  logic [PCT_W-1:0] int_pct_t0_i,
    input  logic [PCT_W-1:0] fp_pct_t0_i,
    input  logic [IPC_W-1:0] ipc_t0_i,
    input  logic [PCT_W-1:0] int_pct_t1_i,
    input  logic [PCT_W-1:0] fp_pct_t1_i,
    input  logic [IPC_W-1:0] ipc_t1_i,
    input  logic [1:0]       cfg_i,
    output logic             dec_vld_o,
    output logic [2:0]       dec_code_o
);
    localparam int NTHR  = 2;
    localparam int SUM_W = PCT_W + 1;

    typedef struct packed {
        logic vld;
        dec_e code;
    } out_t;

    logic [PCT_W-1:0] int_pct [NTHR];
    logic [PCT_W-1:0] fp_pct  [NTHR];
    logic [IPC_W-1:0] ipc     [NTHR];
    cls_t             cls     [NTHR];
    dec_e             dec_raw;
    cfg_e             cfg;
    logic             pair;
    out_t             out_d, out_q;

    assign int_pct[0] = int_pct_t0_i;
    assign int_pct[1] = int_pct_t1_i;
    assign fp_pct[0]  = fp_pct_t0_i;
    assign fp_pct[1]  = fp_pct_t1_i;
    assign ipc[0]     = ipc_t0_i;
    assign ipc[1]     = ipc_t1_i;
    assign cfg        = cfg_e'(cfg_i);
    assign pair       = win_vld_t0_i && win_vld_t1_i;

    for (genvar g = 0; g < NTHR; g++) begin : g_cls
        morph_thread_cls #(
            .PCT_W(PCT_W), .IPC_W(IPC_W), .IPC_FRAC(IPC_FRAC),
            .IPC_NUM(IPC_NUM), .IPC_DEN(IPC_DEN),
            .SWP_INT_HI(SWP_INT_HI), .SWP_INT_LO(SWP_INT_LO),
            .SWP_FP_HI(SWP_FP_HI), .SWP_FP_LO(SWP_FP_LO),
            .MIX_MIN(MIX_MIN),
            .STR_FP_MIN(STR_FP_MIN), .STR_FP_MAX(STR_FP_MAX),
            .STR_INT_MIN(STR_INT_MIN), .STR_INT_MAX(STR_INT_MAX),
            .WEAK_MIX_LIM(WEAK_MIX_LIM)
        ) u_cls (
            .int_pct_i(int_pct[g]),
            .fp_pct_i (fp_pct[g]),
            .ipc_i    (ipc[g]),
            .cls_o    (cls[g])
        );
    end

    morph_decide u_decide (
        .cfg_i   (cfg),
        .cls_t0_i(cls[0]),
        .cls_t1_i(cls[1]),
        .dec_o   (dec_raw)
    );

    always_comb begin
        out_d      = out_q;
        out_d.vld  = pair;
        out_d.code = pair ? dec_raw : DEC_STAY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{vld: 1'b0, code: DEC_STAY};
        end else begin
            out_q <= out_d;
        end
    end

    assign dec_vld_o  = out_q.vld;
    assign dec_code_o = out_q.code;

    logic [SUM_W-1:0] mix_t0;
    logic [SUM_W-1:0] mix_t1;
    assign mix_t0 = {1'b0, int_pct_t0_i} + {1'b0, fp_pct_t0_i};
    assign mix_t1 = {1'b0, int_pct_t1_i} + {1'b0, fp_pct_t1_i};

    // R1
    pair_gives_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld_t0_i && win_vld_t1_i) |=> dec_vld_o);

    // R1
    lone_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_vld_t0_i && win_vld_t1_i) |=> (!dec_vld_o && dec_code_o == 3'd0));

    // R8
    fused_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld_t0_i && win_vld_t1_i && cfg_i[1]) |=>
        (dec_code_o == 3'd0 || dec_code_o == 3'd4 || dec_code_o == 3'd5));

    // R2
    base_no_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld_t0_i && win_vld_t1_i && !cfg_i[1]) |=> (dec_code_o <= 3'd3));

    // R4
    fuse0_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && dec_code_o == 3'd2) |-> ($past(mix_t0) >= SUM_W'(MIX_MIN)));

    // R4
    fuse1_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && dec_code_o == 3'd3) |-> ($past(mix_t1) >= SUM_W'(MIX_MIN)));

    // R8
    fused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld_t0_i && win_vld_t1_i && cfg_i == 2'd2 && mix_t0 >= SUM_W'(MIX_MIN))
        |=> (dec_code_o == 3'd0));

endmodule

// File: tb/morph_rule_eval_tb.sv
module morph_rule_eval_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       v0 = 1'b0, v1 = 1'b0;
    logic [6:0] i0 = '0, f0 = '0, i1 = '0, f1 = '0;
    logic [9:0] p0 = '0, p1 = '0;
    logic [1:0] cfg = '0;
    logic       dvld;
    logic [2:0] dcode;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    morph_rule_eval u_dut (
        .clk(clk), .rst_n(rst_n),
        .win_vld_t0_i(v0), .win_vld_t1_i(v1),
        .int_pct_t0_i(i0), .fp_pct_t0_i(f0), .ipc_t0_i(p0),
        .int_pct_t1_i(i1), .fp_pct_t1_i(f1), .ipc_t1_i(p1),
        .cfg_i(cfg), .dec_vld_o(dvld), .dec_code_o(dcode)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] cfg;
        logic [6:0] i0;
        logic [6:0] f0;
        logic [9:0] p0;
        logic [6:0] i1;
        logic [6:0] f1;
        logic [9:0] p1;
        logic [2:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 2'd0, 7'd50, 7'd5,  10'd200, 7'd10, 7'd40, 10'd200, 3'd0}, // R2 nothing holds
        '{4'd2, 2'd0, 7'd30, 7'd5,  10'd200, 7'd44, 7'd20, 10'd200, 3'd1}, // R2 on bounds
        '{4'd2, 2'd0, 7'd30, 7'd5,  10'd200, 7'd43, 7'd20, 10'd200, 3'd0}, // R2 one short
        '{4'd3, 2'd0, 7'd10, 7'd26, 10'd200, 7'd20, 7'd13, 10'd200, 3'd1}, // R3 on bounds
        '{4'd3, 2'd0, 7'd10, 7'd25, 10'd200, 7'd20, 7'd13, 10'd200, 3'd0}, // R3 one short
        '{4'd2, 2'd1, 7'd50, 7'd0,  10'd200, 7'd20, 7'd0,  10'd200, 3'd1}, // R2 swapped placement
        '{4'd2, 2'd0, 7'd50, 7'd0,  10'd200, 7'd20, 7'd0,  10'd200, 3'd0}, // R2 same mix normal
        '{4'd4, 2'd0, 7'd30, 7'd20, 10'd300, 7'd10, 7'd10, 10'd102, 3'd2}, // R4 mix 50, R5 ipc limit
        '{4'd5, 2'd0, 7'd30, 7'd20, 10'd300, 7'd10, 7'd10, 10'd103, 3'd0}, // R5 ipc one over
        '{4'd5, 2'd0, 7'd30, 7'd20, 10'd300, 7'd30, 7'd30, 10'd50,  3'd0}, // R5 weak mix 60
        '{4'd5, 2'd0, 7'd30, 7'd20, 10'd300, 7'd40, 7'd19, 10'd50,  3'd2}, // R5 weak mix 59
        '{4'd7, 2'd0, 7'd20, 7'd5,  10'd80,  7'd44, 7'd17, 10'd500, 3'd3}, // R7 fuse beats swap
        '{4'd4, 2'd0, 7'd20, 7'd5,  10'd80,  7'd30, 7'd31, 10'd500, 3'd0}, // R4 fp above band
        '{4'd4, 2'd0, 7'd20, 7'd5,  10'd80,  7'd40, 7'd16, 10'd500, 3'd0}, // R4 fp below band
        '{4'd4, 2'd0, 7'd20, 7'd5,  10'd80,  7'd45, 7'd20, 10'd500, 3'd1}, // R4 int above band
        '{4'd6, 2'd0, 7'd30, 7'd20, 10'd100, 7'd26, 7'd24, 10'd100, 3'd2}, // R6 tie, t0 on int core
        '{4'd6, 2'd1, 7'd30, 7'd20, 10'd100, 7'd26, 7'd24, 10'd100, 3'd3}, // R6 tie, t1 on int core
        '{4'd8, 2'd2, 7'd30, 7'd19, 10'd200, 7'd10, 7'd10, 10'd200, 3'd4}, // R8 strong mix 49
        '{4'd8, 2'd2, 7'd30, 7'd20, 10'd200, 7'd50, 7'd0,  10'd200, 3'd0}, // R8 mix 50, swap ignored
        '{4'd9, 2'd2, 7'd30, 7'd10, 10'd200, 7'd50, 7'd0,  10'd200, 3'd5}, // R9 exit with exchange
        '{4'd8, 2'd3, 7'd10, 7'd5,  10'd200, 7'd40, 7'd9,  10'd200, 3'd4}, // R8 t1 strong exits
        '{4'd8, 2'd3, 7'd10, 7'd5,  10'd50,  7'd40, 7'd30, 10'd200, 3'd0}, // R8 fuse rule ignored
        '{4'd9, 2'd3, 7'd10, 7'd30, 10'd200, 7'd20, 7'd10, 10'd200, 3'd5}  // R9 exit via fp rule
    };

    task automatic check(input string req, input logic exp_v, input logic [2:0] exp_c);
        checks++;
        if (dvld !== exp_v || dcode !== exp_c) begin
            errors++;
            $display("FAIL %s: vld=%0b code=%0d expected vld=%0b code=%0d",
                     req, dvld, dcode, exp_v, exp_c);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 in reset", 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", 1'b0, 3'd0);

        // R1: a lone valid from either profiler gives no decision
        i0 = 7'd30; f0 = 7'd5; p0 = 10'd200; i1 = 7'd44; f1 = 7'd20; p1 = 10'd200; cfg = 2'd0;
        v0 = 1'b1;
        @(negedge clk);
        v0 = 1'b0;
        check("R1 lone t0 valid", 1'b0, 3'd0);
        v1 = 1'b1;
        @(negedge clk);
        v1 = 1'b0;
        check("R1 lone t1 valid", 1'b0, 3'd0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            cfg = VECS[k].cfg;
            i0 = VECS[k].i0; f0 = VECS[k].f0; p0 = VECS[k].p0;
            i1 = VECS[k].i1; f1 = VECS[k].f1; p1 = VECS[k].p1;
            v0 = 1'b1; v1 = 1'b1;
            @(negedge clk);
            v0 = 1'b0; v1 = 1'b0;
            check($sformatf("R%0d vec %0d", VECS[k].req, k), 1'b1, VECS[k].exp);
            @(negedge clk);
            check("R1 pulse ends", 1'b0, 3'd0);
        end

        // R1: back-to-back pair windows each give a decision
        @(negedge clk);
        cfg = 2'd0; i0 = 7'd30; f0 = 7'd5; p0 = 10'd200; i1 = 7'd44; f1 = 7'd20; p1 = 10'd200;
        v0 = 1'b1; v1 = 1'b1;
        @(negedge clk);
        check("R1 back-to-back first", 1'b1, 3'd1);
        i1 = 7'd10;
        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
        check("R1 back-to-back second", 1'b1, 3'd0);

        // R10: reset wins over a pending window
        @(negedge clk);
        i1 = 7'd44; v0 = 1'b1; v1 = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        v0 = 1'b0; v1 = 1'b0;
        check("R10 reset during window", 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", 1'b0, 3'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule